// File: doc/BRIEF.md
# Gigabit Link Master/Slave Role Resolver

This block settles which end of a 1000BASE-T copper link drives the reference timing (master) and which one recovers it (slave). Once the local and link-partner role parameters have been exchanged, a negotiation controller presents both sets in one cycle and raises a qualifying strobe. The parameters are the manual-override enable, the manual role value, the multi-port/single-port flag and an 11-bit random seed. The block answers one clock later.

A resolved answer reports the role with the fault flag clear. Two override settings that clash set the fault flag and request a negotiation restart. When the seeds are identical and nothing else separates the two stations, the block asks for a fresh local seed and counts the failed attempt. A bounded run of such ties ends in a fault and a restart request. The seed source and the page transport belong to the surrounding controller.

Top module: `gbe_ms_resolver`

## Requirements
- R1: While `rst_n` is low and in the cycle after its release, all five outputs are 0 and the tie count is zero.
- R2: If exactly one station has its manual enable set, that station takes the role its manual value names (1 = master). The other station takes the opposite role, so the local result is `loc_man_val` when the local station is manual, and the inverse of `par_man_val` when only the partner is.
- R3: If both stations are manual with different manual values, the local result equals `loc_man_val` and `cfg_fault` is 0.
- R4: If both stations are manual with equal manual values, `cfg_fault` becomes 1, `role_master` becomes 0, and `restart_req` and `res_valid` pulse for one cycle.
- R5: If neither station is manual and their port-type flags differ, the station with the multi-port flag (1) becomes master.
- R6: If neither station is manual and the port-type flags match, the station with the larger unsigned seed becomes master. The seeds cover the full range from 0 to 2047.
- R7: A tie on seeds (R6 case, equal seeds) that is not the final allowed one pulses `seed_req` only. `res_valid`, `role_master` and `cfg_fault` keep their values.
- R8: The seventh tie in a row, with no resolved outcome in between, pulses `restart_req` and `res_valid` and sets `cfg_fault` instead of pulsing `seed_req`. The tie count then restarts from zero.
- R9: Any non-tie outcome clears the tie count, and a successful one clears `cfg_fault`. A series of ties interrupted by a success needs seven further ties before a fault.
- R10: A station's manual value has no effect while its manual enable is 0. Port-type flags have no effect while either station is manual.
- R11: Outputs update on the rising edge that samples `cfg_valid` high. With `cfg_valid` low, the held outputs do not change and the pulse outputs stay 0, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Both parameter sets are valid this cycle |
| loc_man_en | input | 1 | Local manual role override enable |
| loc_man_val | input | 1 | Local manual role value, 1 = master |
| loc_multi_port | input | 1 | Local device is multi-port |
| loc_seed | input | 11 | Local random seed |
| par_man_en | input | 1 | Partner manual role override enable |
| par_man_val | input | 1 | Partner manual role value, 1 = master |
| par_multi_port | input | 1 | Partner device is multi-port |
| par_seed | input | 11 | Partner random seed |
| res_valid | output | 1 | One-cycle pulse: a final outcome (role or fault) was produced |
| role_master | output | 1 | Held result: 1 = local station is master |
| cfg_fault | output | 1 | Held configuration fault flag |
| restart_req | output | 1 | One-cycle pulse requesting negotiation restart |
| seed_req | output | 1 | One-cycle pulse requesting a new local seed |

## Verification
The tie-count limit and the fault path meet in one cycle when the seventh equal-seed presentation arrives. The counter must wrap to zero on the same edge that raises the fault and the restart pulse, and that edge must not also request a seed. The bench provokes this by presenting seven ties in a row. It checks that the first six give only seed requests and the seventh gives fault and restart with no seed request. It then shows that the count really restarted: six more ties must not fault, and a success placed mid-series must push the fault out by a full seven further ties.

// File: rtl/ms_role_pkg.sv
// Package: shared types for the master/slave role resolver.
// Assumes: one outcome code per presentation of a parameter pair.
package ms_role_pkg;

    // Outcome of one comparison of local and partner role parameters.
    typedef enum logic [1:0] {
        DEC_SLAVE  = 2'd0,
        DEC_MASTER = 2'd1,
        DEC_FAULT  = 2'd2,
        DEC_TIE    = 2'd3
    } ms_dec_e;

    // Per-station role parameters, seed excluded.
    typedef struct packed {
        logic man_en;
        logic man_val;
        logic multi;
    } ms_cfg_t;

endpackage

// File: rtl/ms_seed_cmp.sv
// Module: unsigned magnitude compare of two seeds, MSB first.
// Assumes: both seeds are plain unsigned numbers of SEED_W bits.
module ms_seed_cmp #(
    parameter int SEED_W = 11
) (
    input  logic [SEED_W-1:0] seed_a,
    input  logic [SEED_W-1:0] seed_b,
    output logic              a_gt_b,
    output logic              a_eq_b
);

    // Walk from the most significant bit, deciding at the first difference.
    always_comb begin
        logic gt_acc;
        logic eq_acc;
        gt_acc = 1'b0;
        eq_acc = 1'b1;
        for (int i = SEED_W - 1; i >= 0; i--) begin
            gt_acc = gt_acc | (eq_acc & seed_a[i] & ~seed_b[i]);
            eq_acc = eq_acc & ~(seed_a[i] ^ seed_b[i]);
        end
        a_gt_b = gt_acc;
        a_eq_b = eq_acc;
    end

endmodule

// File: rtl/ms_role_decide.sv
// Module: priority ladder deciding the local role from both parameter sets.
// Order: manual override, then port type, then seed magnitude.
// Assumes: seed compare results refer to local (a) versus partner (b).
module ms_role_decide
    import ms_role_pkg::*;
(
    input  ms_cfg_t loc_cfg,
    input  ms_cfg_t par_cfg,
    input  logic    seed_gt,
    input  logic    seed_eq,
    output ms_dec_e dec
);

    // Evaluate the ladder; the first rung that separates the stations wins.
    always_comb begin
        if (loc_cfg.man_en && par_cfg.man_en) begin
            if (loc_cfg.man_val == par_cfg.man_val) dec = DEC_FAULT;
            else dec = loc_cfg.man_val ? DEC_MASTER : DEC_SLAVE;
        end else if (loc_cfg.man_en) begin
            dec = loc_cfg.man_val ? DEC_MASTER : DEC_SLAVE;
        end else if (par_cfg.man_en) begin
            dec = par_cfg.man_val ? DEC_SLAVE : DEC_MASTER;
        end else if (loc_cfg.multi != par_cfg.multi) begin
            dec = loc_cfg.multi ? DEC_MASTER : DEC_SLAVE;
        end else if (seed_eq) begin
            dec = DEC_TIE;
        end else begin
            dec = seed_gt ? DEC_MASTER : DEC_SLAVE;
        end
    end

endmodule

// File: rtl/ms_try_counter.sv
// Module: counts consecutive seed ties and flags the final allowed one.
// Assumes: clear and tie_hit never assert together (the caller guarantees it).
module ms_try_counter #(
    parameter int MAX_TRIES = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tie_hit,
    input  logic clear,
    output logic last_try
);

    localparam int CNT_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_TRIES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last_try = (cnt_q == LAST_VAL);

    // Advance on a tie, wrap after the final one, clear on any resolution.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clear)         cnt_q <= '0;
        else if (tie_hit)       cnt_q <= last_try ? '0 : cnt_q + 1'b1;
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL);

    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tie_hit && !clear && !last_try) |=> (cnt_q != '0));

    assert_cnt_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tie_hit && last_try) |=> (cnt_q == '0));

    assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/gbe_ms_resolver.sv
// Module: top of the master/slave role resolver.
// Samples both parameter sets when cfg_valid is high, answers one cycle later
// with a role, a fault plus restart, or a request for a fresh local seed.
// Assumes: the controller supplies a new local seed before re-presenting a tie.
module gbe_ms_resolver
    import ms_role_pkg::*;
#(
    parameter int SEED_W    = 11,
    parameter int MAX_TRIES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              loc_man_en,
    input  logic              loc_man_val,
    input  logic              loc_multi_port,
    input  logic [SEED_W-1:0] loc_seed,
    input  logic              par_man_en,
    input  logic              par_man_val,
    input  logic              par_multi_port,
    input  logic [SEED_W-1:0] par_seed,
    output logic              res_valid,
    output logic              role_master,
    output logic              cfg_fault,
    output logic              restart_req,
    output logic              seed_req
);

    ms_cfg_t loc_cfg;
    ms_cfg_t par_cfg;
    ms_dec_e dec;
    logic    seed_gt;
    logic    seed_eq;
    logic    last_try;
    logic    tie_hit;
    logic    resolved;
    logic    final_tie;

    assign loc_cfg = '{man_en: loc_man_en, man_val: loc_man_val, multi: loc_multi_port};
    assign par_cfg = '{man_en: par_man_en, man_val: par_man_val, multi: par_multi_port};

    ms_seed_cmp #(.SEED_W(SEED_W)) seed_cmp_i (
        .seed_a (loc_seed),
        .seed_b (par_seed),
        .a_gt_b (seed_gt),
        .a_eq_b (seed_eq)
    );

    ms_role_decide decide_i (
        .loc_cfg (loc_cfg),
        .par_cfg (par_cfg),
        .seed_gt (seed_gt),
        .seed_eq (seed_eq),
        .dec     (dec)
    );

    assign tie_hit   = cfg_valid && (dec == DEC_TIE);
    assign resolved  = cfg_valid && (dec != DEC_TIE);
    assign final_tie = tie_hit && last_try;

    ms_try_counter #(.MAX_TRIES(MAX_TRIES)) try_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tie_hit  (tie_hit),
        .clear    (resolved),
        .last_try (last_try)
    );

    // Pulse outputs: one cycle per presentation, chosen by the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            restart_req <= 1'b0;
            seed_req    <= 1'b0;
        end else begin
            res_valid   <= resolved || final_tie;
            restart_req <= (resolved && dec == DEC_FAULT) || final_tie;
            seed_req    <= tie_hit && !last_try;
        end
    end

    // Held result: updated only by a final outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            role_master <= 1'b0;
            cfg_fault   <= 1'b0;
        end else if ((resolved && dec == DEC_FAULT) || final_tie) begin
            role_master <= 1'b0;
            cfg_fault   <= 1'b1;
        end else if (resolved) begin
            role_master <= (dec == DEC_MASTER);
            cfg_fault   <= 1'b0;
        end
    end

    assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(seed_req && (restart_req || res_valid)));

    assert_fault_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_fault) |-> restart_req);

    assert_manual_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && loc_man_en && par_man_en && (loc_man_val == par_man_val))
        |=> (cfg_fault && restart_req && !role_master));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> (!res_valid && !seed_req && !restart_req &&
                        $stable(role_master) && $stable(cfg_fault)));

    assert_master_nofault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        role_master |-> !cfg_fault);

    assert_local_manual_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && loc_man_en && !par_man_en) |=> (role_master == $past(loc_man_val)));

endmodule

// File: tb/gbe_ms_resolver_tb_top.sv
// Bench: sweeps every combination of the six role flags against three seed
// relations, then drives the tie-limit, boundary, ignore and idle cases.
module gbe_ms_resolver_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SW         = 11;
    localparam int TRIES      = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic          loc_man_en = 1'b0, loc_man_val = 1'b0, loc_multi_port = 1'b0;
    logic          par_man_en = 1'b0, par_man_val = 1'b0, par_multi_port = 1'b0;
    logic [SW-1:0] loc_seed = '0, par_seed = '0;
    logic          res_valid, role_master, cfg_fault, restart_req, seed_req;

    int checks = 0;
    int errors = 0;
    int tie_cnt = 0;
    logic exp_m = 1'b0;
    logic exp_f = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gbe_ms_resolver #(.SEED_W(SW), .MAX_TRIES(TRIES)) dut_i (
        .clk, .rst_n, .cfg_valid,
        .loc_man_en, .loc_man_val, .loc_multi_port, .loc_seed,
        .par_man_en, .par_man_val, .par_multi_port, .par_seed,
        .res_valid, .role_master, .cfg_fault, .restart_req, .seed_req
    );

    // Output vector order: res_valid, role_master, cfg_fault, restart_req, seed_req.
    task automatic chk(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {res_valid, role_master, cfg_fault, restart_req, seed_req};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // 0 slave, 1 master, 2 fault, 3 tie.
    function automatic int model(logic le, logic lv, logic lm, logic [SW-1:0] ls,
                                 logic pe, logic pv, logic pm, logic [SW-1:0] ps);
        if (le && pe) return (lv == pv) ? 2 : int'(lv);
        if (le) return int'(lv);
        if (pe) return int'(!pv);
        if (lm != pm) return int'(lm);
        if (ls == ps) return 3;
        return (ls > ps) ? 1 : 0;
    endfunction

    task automatic apply(input logic le, input logic lv, input logic lm, input logic [SW-1:0] ls,
                         input logic pe, input logic pv, input logic pm, input logic [SW-1:0] ps,
                         input string force_tag);
        int o;
        string tag;
        logic [4:0] exp;
        o = model(le, lv, lm, ls, pe, pv, pm, ps);
        if (o == 2) begin
            tag = "R4"; exp_f = 1'b1; exp_m = 1'b0; tie_cnt = 0;
            exp = {1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
        end else if (o == 3) begin
            if (tie_cnt == TRIES - 1) begin
                tag = "R8"; exp_f = 1'b1; exp_m = 1'b0; tie_cnt = 0;
                exp = {1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
            end else begin
                tag = "R7"; tie_cnt++;
                exp = {1'b0, exp_m, exp_f, 1'b0, 1'b1};
            end
        end else begin
            if (le && pe) tag = "R3";
            else if (le || pe) tag = "R2";
            else if (lm != pm) tag = "R5";
            else tag = "R6";
            exp_m = o[0]; exp_f = 1'b0; tie_cnt = 0;
            exp = {1'b1, exp_m, 1'b0, 1'b0, 1'b0};
        end
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        cfg_valid = 1'b1;
        loc_man_en = le; loc_man_val = lv; loc_multi_port = lm; loc_seed = ls;
        par_man_en = pe; par_man_val = pv; par_multi_port = pm; par_seed = ps;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(tag, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, during and just after reset.
        repeat (3) @(negedge clk);
        chk("R1", 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 5'b00000);

        // Sweep all flag combinations against three seed relations (covers R2..R7, R10).
        for (int c = 0; c < 64; c++) begin
            for (int s = 0; s < 3; s++) begin
                logic [SW-1:0] a, b;
                if (s == 0) begin a = SW'(100 + c); b = SW'(105 + c); end
                else if (s == 1) begin a = SW'(2047 - c); b = SW'(3); end
                else begin a = SW'(c * 31); b = SW'(c * 31); end
                apply(c[5], c[4], c[3], a, c[2], c[1], c[0], b, "");
            end
        end

        // R6: seed extremes.
        apply(0, 0, 1, 11'd0,    0, 0, 1, 11'd2047, "R6");
        apply(0, 0, 0, 11'd2047, 0, 0, 0, 11'd2046, "R6");

        // R8: seven ties in a row; first six ask for seeds, seventh faults.
        for (int t = 0; t < TRIES; t++) apply(0, 1, 0, 11'd555, 0, 0, 0, 11'd555, "");
        // R8: count restarted, six more ties then a success.
        for (int t = 0; t < TRIES - 1; t++) apply(0, 0, 1, 11'd9, 0, 1, 1, 11'd9, "R8");
        apply(0, 0, 1, 11'd10, 0, 0, 1, 11'd9, "R9");

        // R9: three ties, success, then seven further ties needed for fault.
        for (int t = 0; t < 3; t++) apply(0, 0, 0, 11'd77, 0, 0, 0, 11'd77, "R9");
        apply(0, 0, 0, 11'd1, 0, 0, 0, 11'd2, "R9");
        for (int t = 0; t < TRIES; t++) apply(0, 0, 0, 11'd300, 0, 0, 0, 11'd300, "R9");

        // R10: manual value ignored without enable; port type ignored under manual.
        apply(0, 1, 0, 11'd5,  1, 1, 1, 11'd900, "R10");
        apply(1, 0, 1, 11'd900, 0, 1, 0, 11'd5,  "R10");
        apply(0, 1, 1, 11'd5,  0, 1, 1, 11'd6,  "R10");

        // R11: inputs toggling with valid low change nothing.
        apply(0, 0, 1, 11'd0, 0, 0, 0, 11'd0, "R5");
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            loc_man_en = t[0]; par_man_en = t[1]; loc_man_val = t[2];
            par_man_val = ~t[2]; loc_seed = SW'(t * 99); par_seed = SW'(t);
            @(negedge clk);
            chk("R11", {1'b0, exp_m, exp_f, 1'b0, 1'b0});
        end

        // R1: reset mid-run clears held state and the tie count.
        for (int t = 0; t < 4; t++) apply(0, 0, 0, 11'd8, 0, 0, 0, 11'd8, "R7");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_m = 1'b0; exp_f = 1'b0; tie_cnt = 0;
        chk("R1", 5'b00000);
        for (int t = 0; t < TRIES; t++) apply(0, 0, 0, 11'd8, 0, 0, 0, 11'd8, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule